// File: doc/BRIEF.md
# Ping-Pong Flicker Sample Buffer

This block stores instantaneous-flicker samples for later statistical processing. It has two equal memory banks. One bank fills with incoming samples. The other bank belongs to a processing agent, which reads it, sorts it in place and computes percentiles over it. When the capture bank has taken one full observation interval of samples, the two banks trade places. In the intended deployment `DEPTH` is 16,000 and samples arrive at 26 2/3 Hz, so each bank covers ten minutes. The default is smaller so the block elaborates quickly.

A host gives one start strobe. After that the block runs without further help, one interval after another. At each swap it raises a one-cycle ready pulse and the index of the filled bank, and marks that bank as held. The agent must return the bank with a release strobe before the next swap is due. If it does not, the block sets a sticky overrun flag and keeps writing the current bank again from address 0. The agent reaches its bank through a synchronous read/write port with one cycle of read latency.

Top module: `flk_pingpong_buf`

## Requirements
- R1: After reset, `bank_ready`, `bank_held` and `overrun` are 0. Samples presented before the first `start` are discarded and never appear in either bank.
- R2: A `start` strobe arms capture at address 0 of bank 0 and clears `bank_held` and `overrun`. A sample presented in the same cycle as `start` is discarded. A later `start` re-arms the block the same way.
- R3: While armed, each cycle with `smp_valid` high writes `smp_data` to the next address of the capture bank, beginning at 0. The write at address `DEPTH-1` completes the interval.
- R4: When an interval completes and the agent's bank is free, the following happens:
  - capture moves to the other bank, at address 0;
  - `bank_ready` is 1 for exactly the one cycle after the final write;
  - in that cycle `ready_bank` gives the index of the bank just filled (0 or 1);
  - `bank_held` becomes 1.
- R5: `cons_release` clears `bank_held` from the next cycle on. A release in the same cycle as the final write of an interval counts as freeing the bank, so that swap proceeds.
- R6: An interval that completes while `bank_held` is 1, with no release, has these effects:
  - `overrun` is set and stays set until the next `start`;
  - no `bank_ready` pulse occurs;
  - capture stays in the same bank and restarts at address 0, overwriting earlier samples.
- R7: The consumer port always addresses the bank that is not capturing.
  - A read (`cons_en`=1, `cons_we`=0) returns the word on `cons_rdata` one cycle later.
  - A write (`cons_en`=1, `cons_we`=1) stores `cons_wdata` at that address.
- R8: Successive `bank_ready` pulses within one run report alternating bank indices, starting with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Host strobe that arms or re-arms capture |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Instantaneous-flicker sample |
| cons_en | input | 1 | Consumer access enable |
| cons_we | input | 1 | Consumer write (1) or read (0) |
| cons_addr | input | $clog2(DEPTH) | Consumer word address |
| cons_wdata | input | DATA_W | Consumer write data |
| cons_rdata | output | DATA_W | Consumer read data, one cycle after the request |
| cons_release | input | 1 | Consumer hands its bank back |
| bank_ready | output | 1 | One-cycle pulse after each swap |
| ready_bank | output | 1 | Index of the bank just filled |
| bank_held | output | 1 | Consumer currently owns a filled bank |
| overrun | output | 1 | Sticky flag: an interval ended while the bank was held |

## Verification
Directed intervals come first. These are:
- prompt releases, which show the bank alternation and that every stored word sits at its sample order;
- a withheld release, which separates a real swap from a wrap inside the same bank;
- a release in the same cycle as the last write of an interval, which pins down which way that race resolves;
- samples sent before arming, which show they leave no trace;
- consumer writes followed by reads, which show in-place update works.

A seeded random phase then mixes sparse sample strobes, occasional releases, restarts and consumer reads and writes. Every consumer read is compared with a bench model of both banks, so data from the wrong bank or from the wrong cycle shows up as a mismatch.

// File: rtl/flk_pkg.sv
package flk_pkg;
   typedef logic bank_idx_t;

   function automatic bank_idx_t flk_other_bank(input bank_idx_t b);
      return ~b;
   endfunction
endpackage

// File: rtl/flk_ram_sp.sv
module flk_ram_sp #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 1024,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end
endmodule

// File: rtl/flk_wr_ctrl.sv
module flk_wr_ctrl
   import flk_pkg::*;
#(
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          smp_valid,
   input  logic          cons_release,
   output logic          wr_en,
   output logic [AW-1:0] wr_ptr,
   output bank_idx_t     wr_bank,
   output logic          bank_ready,
   output bank_idx_t     ready_bank,
   output logic          bank_held,
   output logic          overrun
);
   localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

   logic running;
   logic at_last;
   logic bank_free;

   assign wr_en     = running & smp_valid & ~start;
   assign at_last   = (wr_ptr == LAST_ADDR);
   assign bank_free = ~bank_held | cons_release;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running    <= 1'b0;
         wr_ptr     <= '0;
         wr_bank    <= 1'b0;
         bank_ready <= 1'b0;
         ready_bank <= 1'b0;
         bank_held  <= 1'b0;
         overrun    <= 1'b0;
      end else if (start) begin
         running    <= 1'b1;
         wr_ptr     <= '0;
         wr_bank    <= 1'b0;
         bank_ready <= 1'b0;
         bank_held  <= 1'b0;
         overrun    <= 1'b0;
      end else begin
         bank_ready <= 1'b0;
         if (cons_release) bank_held <= 1'b0;
         if (wr_en) begin
            if (!at_last) begin
               wr_ptr <= wr_ptr + 1'b1;
            end else begin
               wr_ptr <= '0;
               if (bank_free) begin
                  wr_bank    <= flk_other_bank(wr_bank);
                  ready_bank <= wr_bank;
                  bank_ready <= 1'b1;
                  bank_held  <= 1'b1;
               end else begin
                  overrun <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/flk_pingpong_buf.sv
module flk_pingpong_buf
   import flk_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 1024,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              cons_en,
   input  logic              cons_we,
   input  logic [AW-1:0]     cons_addr,
   input  logic [DATA_W-1:0] cons_wdata,
   output logic [DATA_W-1:0] cons_rdata,
   input  logic              cons_release,
   output logic              bank_ready,
   output logic              ready_bank,
   output logic              bank_held,
   output logic              overrun
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end

   logic          wr_en;
   logic [AW-1:0] wr_ptr;
   bank_idx_t     wr_bank;
   bank_idx_t     rd_sel;

   logic [1:0]        ram_en;
   logic [1:0]        ram_we;
   logic [AW-1:0]     ram_addr [2];
   logic [DATA_W-1:0] ram_wd   [2];
   logic [DATA_W-1:0] ram_rd   [2];

   flk_wr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .smp_valid    (smp_valid),
      .cons_release (cons_release),
      .wr_en        (wr_en),
      .wr_ptr       (wr_ptr),
      .wr_bank      (wr_bank),
      .bank_ready   (bank_ready),
      .ready_bank   (ready_bank),
      .bank_held    (bank_held),
      .overrun      (overrun)
   );

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic cap;
      assign cap         = (wr_bank == 1'(b));
      assign ram_en[b]   = cap ? wr_en : cons_en;
      assign ram_we[b]   = cap ? 1'b1 : cons_we;
      assign ram_addr[b] = cap ? wr_ptr : cons_addr;
      assign ram_wd[b]   = cap ? smp_data : cons_wdata;

      flk_ram_sp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
         .clk   (clk),
         .en    (ram_en[b]),
         .we    (ram_we[b]),
         .addr  (ram_addr[b]),
         .wdata (ram_wd[b]),
         .rdata (ram_rd[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   rd_sel <= 1'b0;
      else if (cons_en && !cons_we) rd_sel <= flk_other_bank(wr_bank);
   end

   assign cons_rdata = ram_rd[rd_sel];
endmodule

// File: rtl/flk_buf_chk.sv
module flk_buf_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic cons_release,
   input logic bank_ready,
   input logic ready_bank,
   input logic bank_held,
   input logic overrun
);
   logic started;
   logic have_rb;
   logic last_rb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started <= 1'b0;
         have_rb <= 1'b0;
         last_rb <= 1'b0;
      end else if (start) begin
         started <= 1'b1;
         have_rb <= 1'b0;
      end else if (bank_ready) begin
         have_rb <= 1'b1;
         last_rb <= ready_bank;
      end
   end

   assert_no_ready_unarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> !bank_ready);

   assert_ready_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bank_ready |=> !bank_ready);

   assert_ready_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bank_ready |-> bank_held);

   assert_release_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cons_release && !start) |=> (!bank_held || bank_ready));

   assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !start) |=> overrun);

   assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(bank_held && !cons_release));

   assert_alternate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_ready && have_rb) |-> (ready_bank != last_rb));
endmodule

bind flk_pingpong_buf flk_buf_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .cons_release (cons_release),
   .bank_ready   (bank_ready),
   .ready_bank   (ready_bank),
   .bank_held    (bank_held),
   .overrun      (overrun)
);

// File: tb/sim_flk_pingpong_buf.sv
`timescale 1ns/1ps
module sim_flk_pingpong_buf;
   localparam int DW    = 12;
   localparam int DEPTH = 8;
   localparam int AW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          smp_valid = 1'b0;
   logic [DW-1:0] smp_data = '0;
   logic          cons_en = 1'b0;
   logic          cons_we = 1'b0;
   logic [AW-1:0] cons_addr = '0;
   logic [DW-1:0] cons_wdata = '0;
   logic [DW-1:0] cons_rdata;
   logic          cons_release = 1'b0;
   logic          bank_ready;
   logic          ready_bank;
   logic          bank_held;
   logic          overrun;

   always #2.5 clk = ~clk;

   flk_pingpong_buf #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (.*);

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // bench model
   logic [DW-1:0] m_mem   [2][DEPTH];
   bit            m_known [2][DEPTH];
   bit            m_run = 0;
   bit            m_bank = 0;
   int            m_ptr = 0;
   bit            m_held = 0;
   bit            m_ovr = 0;
   int            ready_seen = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input bit v, input logic [DW-1:0] d, input bit rel, input bit st,
                       input bit en, input bit we, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd);
      bit rd_chk;
      logic [DW-1:0] rd_exp;
      bit e_rdy;
      bit e_rb;
      bit old_held;
      @(negedge clk);
      smp_valid = v; smp_data = d; cons_release = rel; start = st;
      cons_en = en; cons_we = we; cons_addr = a; cons_wdata = wd;
      rd_chk = en && !we && m_known[~m_bank][a];
      rd_exp = m_mem[~m_bank][a];
      if (en && we) begin
         m_mem[~m_bank][a] = wd;
         m_known[~m_bank][a] = 1;
      end
      e_rdy = 0; e_rb = 0;
      old_held = m_held;
      if (st) begin
         m_run = 1; m_bank = 0; m_ptr = 0; m_held = 0; m_ovr = 0;
      end else begin
         if (rel) m_held = 0;
         if (m_run && v) begin
            m_mem[m_bank][m_ptr] = d;
            m_known[m_bank][m_ptr] = 1;
            if (m_ptr == DEPTH - 1) begin
               m_ptr = 0;
               if (!old_held || rel) begin
                  e_rb = m_bank; m_bank = ~m_bank; m_held = 1; e_rdy = 1;
               end else begin
                  m_ovr = 1;
               end
            end else begin
               m_ptr++;
            end
         end
      end
      @(posedge clk);
      #1;
      chk(bank_ready == e_rdy, "R4 bank_ready", bank_ready, e_rdy);
      if (e_rdy) begin
         chk(ready_bank == e_rb, "R8 ready_bank", ready_bank, e_rb);
         ready_seen++;
      end
      chk(bank_held == m_held, "R5 bank_held", bank_held, m_held);
      chk(overrun == m_ovr, "R6 overrun", overrun, m_ovr);
      if (rd_chk) chk(cons_rdata == rd_exp, "R7 R3 cons_rdata", cons_rdata, rd_exp);
      smp_valid = 0; start = 0; cons_release = 0; cons_en = 0; cons_we = 0;
   endtask

   task automatic idle();
      step(0, '0, 0, 0, 0, 0, '0, '0);
   endtask

   task automatic push(input logic [DW-1:0] d, input bit rel);
      step(1, d, rel, 0, 0, 0, '0, '0);
   endtask

   task automatic read_all();
      for (int i = 0; i < DEPTH; i++) step(0, '0, 0, 0, 1, 0, AW'(i), '0);
      idle();
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int seed;
      int cnt;
      seed = $urandom(32'h5eed);
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(bank_ready == 0, "R1 reset bank_ready", bank_ready, 0);
      chk(bank_held == 0, "R1 reset bank_held", bank_held, 0);
      chk(overrun == 0, "R1 reset overrun", overrun, 0);
      rst_n = 1;
      // R1 samples before start are discarded
      for (int i = 0; i < 2 * DEPTH + 3; i++) push(DW'(12'hF00 + i), 0);
      // R2 arm; sample in the start cycle is discarded
      step(1, 12'hBAD, 0, 1, 0, 0, '0, '0);
      // R3/R4 first interval into bank 0
      for (int i = 0; i < DEPTH; i++) push(DW'(12'h100 + i), 0);
      read_all();
      for (int i = 0; i < DEPTH; i++) begin
         chk(m_mem[0][i] == DW'(12'h100 + i), "R3 sample order", m_mem[0][i], 12'h100 + i);
      end
      step(0, '0, 1, 0, 0, 0, '0, '0);
      // R8 second interval into bank 1
      for (int i = 0; i < DEPTH; i++) push(DW'(12'h200 + i), 0);
      read_all();
      // R7 in-place write then read
      for (int i = 0; i < DEPTH; i++) step(0, '0, 0, 0, 1, 1, AW'(i), DW'(12'h7A0 - i));
      read_all();
      // R6 overrun: interval ends while bank is held
      for (int i = 0; i < DEPTH + 3; i++) push(DW'(12'h300 + i), 0);
      read_all();
      chk(overrun == 1, "R6 sticky", overrun, 1);
      // R5 release in the same cycle as the final write
      for (int i = 3; i < DEPTH - 1; i++) push(DW'(12'h400 + i), 0);
      push(12'h4FF, 1);
      read_all();
      // R2 restart clears overrun and held
      step(0, '0, 0, 1, 0, 0, '0, '0);
      chk(overrun == 0, "R2 restart overrun", overrun, 0);
      chk(bank_held == 0, "R2 restart held", bank_held, 0);
      for (int i = 0; i < DEPTH; i++) push(DW'(12'h500 + i), 0);
      read_all();
      // random phase
      cnt = 0;
      for (int i = 0; i < 4000; i++) begin
         bit v, rel, st, en, we;
         v   = ($urandom % 3) == 0;
         rel = ($urandom % 20) == 0;
         st  = ($urandom % 900) == 0;
         en  = ($urandom % 2) == 0;
         we  = ($urandom % 4) == 0;
         step(v, DW'($urandom), rel, st, en, we, AW'($urandom), DW'($urandom));
         cnt++;
      end
      chk(ready_seen > 4, "R4 swaps seen", ready_seen, 5);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule